// File: doc/BRIEF.md
# Taxi Fare Meter Core

This block is the counting and pricing core of a taxi meter. It runs entirely on one clock. Two single-cycle enables carry the slow events. A wheel pulse marks a fixed slice of distance. A minute tick marks one minute of elapsed time. The block turns these into a BCD distance in kilometres, a BCD waiting time in minutes, and a BCD fare in tenths of the currency unit. The fare starts from a flat fee.

A level input `start` arms the meter. While it is low, the meter sits cleared and shows the starting fee. With `start` high and `stop` low, the cab is driving: wheel pulses build up distance, and each kilometre completed beyond the free distance is charged at the distance rate. With `stop` high, the cab is waiting: wheel pulses are ignored, minute ticks build up waiting time, and each minute completed beyond the free waiting time is charged at the waiting rate. Two flags show which tariff is armed at any moment. Display scanning and segment decoding belong to the logic around this block.

Top module: `taxi_meter`

## Requirements
- R1: While `start` is low, each clock edge clears the distance, the waiting time and the internal pulse count, and loads the fare with 005.0 (BCD 16'h0050). Both rate flags read 0 while `start` is low.
- R2: With `start` high and `stop` low, every PULSES_PER_KM-th wheel pulse (default 10) advances the distance by one kilometre, on the same edge as the pulse that completes the count.
- R3: `en_dist` is 1 exactly when `start` is high, `stop` is low and the current distance is above 2 km; it is 0 whenever `stop` is high.
- R4: A kilometre step taken while `en_dist` is 1 (the distance before the step is 3 km or more) adds 1.4 to the fare on that same edge.
- R5: With `stop` high, wheel pulses have no effect on the distance or on the pulse count, and each minute tick advances the waiting time by one.
- R6: `en_wait` is 1 exactly when `start` and `stop` are high and the current waiting time is above 2 minutes.
- R7: A minute tick taken while `en_wait` is 1 adds 1.3 to the fare on that same edge.
- R8: In every other cycle the fare holds its value. In particular, a ride within 2 km and at most 2 minutes of waiting keeps the fare at 005.0.
- R9: The fare outputs four BCD digits, from bits [15:12] down to [3:0]: hundreds, tens, units and tenths. Distance and waiting time are each two BCD digits (tens in [7:4], units in [3:0]) and wrap from 99 to 00.
- R10: A charge that would carry past 999.9 leaves the fare at 999.9 (16'h9999), and the fare stays there until `start` drops.
- R11: At most one of `en_dist` and `en_wait` is 1 in any cycle. If both charge requests were ever raised in the same cycle, the distance charge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| start | input | 1 | Meter armed when high; low clears the meter to the starting fee |
| stop | input | 1 | High while the cab waits; low while it drives |
| wheel_pulse | input | 1 | Single-cycle enable, one per distance slice |
| minute_tick | input | 1 | Single-cycle enable, one per minute |
| fare_bcd | output | 16 | Fare, four BCD digits, last digit in tenths |
| km_bcd | output | 8 | Distance in km, two BCD digits |
| min_bcd | output | 8 | Waiting time in minutes, two BCD digits |
| en_dist | output | 1 | Distance tariff armed |
| en_wait | output | 1 | Waiting tariff armed |

## Verification
A wrong pulse count or kilometre digit shows on `km_bcd` at the edge where a step should or should not happen, and the bad threshold decision shows on `en_dist` in that same cycle. A bad BCD carry or a wrong rate digit shows on `fare_bcd` on the first charged edge. A skipped or extra charge leaves a lasting offset in the fare, so it can still be read many cycles later. The bench follows every output cycle by cycle against a decimal model. It runs long patterns that cross both thresholds, both wrap points and the saturation limit.

// File: rtl/taxi_meter_pkg.sv
package taxi_meter_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    // decimal digit number `pos` (0 = least significant) of a non-negative value
    function automatic bcd_digit_t dec_digit(input int value, input int pos);
        int v;
        v = value;
        for (int k = 0; k < pos; k++) begin
            v = v / 10;
        end
        return bcd_digit_t'(v % 10);
    endfunction

    // numeric value of a BCD vector of `ndig` digits
    function automatic int bcd_value(input logic [31:0] bcd, input int ndig);
        int acc;
        acc = 0;
        for (int k = ndig - 1; k >= 0; k--) begin
            acc = acc * 10 + int'(bcd[4*k +: 4]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/taxi_bcd_counter.sv
module taxi_bcd_counter
    import taxi_meter_pkg::*;
#(
    parameter int NDIG = 2
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*NDIG-1:0]     value
);

    typedef struct packed {
        logic [4*NDIG-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        logic carry;
        st_d  = st_q;
        carry = inc;
        for (int i = 0; i < NDIG; i++) begin
            if (carry) begin
                if (st_q.cnt[4*i +: 4] == 4'd9) begin
                    st_d.cnt[4*i +: 4] = 4'd0;
                end else begin
                    st_d.cnt[4*i +: 4] = st_q.cnt[4*i +: 4] + 4'd1;
                    carry              = 1'b0;
                end
            end
        end
        if (clr) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value = st_q.cnt;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit_chk
        AST_COUNT_DIGIT_BCD: assert property (@(posedge clk) disable iff (clr)
            $past(!clr) |-> (st_q.cnt[4*g +: 4] <= 4'd9)) else $error("counter digit not BCD"); // R9
    end

endmodule

// File: rtl/taxi_wheel_divider.sv
module taxi_wheel_divider
    import taxi_meter_pkg::*;
#(
    parameter int PULSES_PER_KM = 10
) (
    input  logic clk,
    input  logic clr,
    input  logic pulse_en,
    output logic km_step
);

    localparam int SUB_W = (PULSES_PER_KM > 1) ? $clog2(PULSES_PER_KM) : 1;
    localparam logic [SUB_W-1:0] LAST_SLICE = SUB_W'(PULSES_PER_KM - 1);

    typedef struct packed {
        logic [SUB_W-1:0] slices;
    } div_state_t;

    div_state_t st_d, st_q;

    assign km_step = pulse_en && (st_q.slices == LAST_SLICE);

    always_comb begin
        st_d = st_q;
        if (pulse_en) begin
            if (st_q.slices == LAST_SLICE) begin
                st_d.slices = '0;
            end else begin
                st_d.slices = st_q.slices + SUB_W'(1);
            end
        end
        if (clr) begin
            st_d.slices = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_SLICE_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
        $past(!clr) |-> (st_q.slices <= LAST_SLICE)) else $error("slice count out of range"); // R2

    AST_SLICE_HELD_IDLE: assert property (@(posedge clk) disable iff (clr)
        !pulse_en |=> $stable(st_q.slices)) else $error("slice count moved without pulse"); // R5

endmodule

// File: rtl/taxi_rate_select.sv
module taxi_rate_select
    import taxi_meter_pkg::*;
#(
    parameter int NDIG     = 2,
    parameter int FREE_KM  = 2,
    parameter int FREE_MIN = 2
) (
    input  logic              run,
    input  logic              stop,
    input  logic [4*NDIG-1:0] km_value,
    input  logic [4*NDIG-1:0] min_value,
    input  logic              km_step,
    input  logic              min_step,
    output logic              en_dist,
    output logic              en_wait,
    output logic              add_dist,
    output logic              add_wait
);

    logic km_over;
    logic min_over;

    always_comb begin
        km_over  = bcd_value(32'(km_value), NDIG) > FREE_KM;
        min_over = bcd_value(32'(min_value), NDIG) > FREE_MIN;
        en_dist  = run && !stop && km_over;
        en_wait  = run && stop && min_over;
        // distance pricing has priority over waiting pricing
        add_dist = en_dist && km_step;
        add_wait = en_wait && min_step && !add_dist;
    end

endmodule

// File: rtl/taxi_fare_accum.sv
module taxi_fare_accum
    import taxi_meter_pkg::*;
#(
    parameter int NDIG      = 4,
    parameter int START_FEE = 50,
    parameter int RATE_A    = 14,
    parameter int RATE_B    = 13
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              add_a,
    input  logic              add_b,
    output logic [4*NDIG-1:0] fare
);

    typedef struct packed {
        logic [4*NDIG-1:0] fare;
    } fare_state_t;

    fare_state_t st_d, st_q;

    logic [NDIG:0]      carry;
    logic [4*NDIG-1:0]  start_vec;
    logic [4*NDIG-1:0]  sum_vec;
    bcd_digit_t         addend  [NDIG];
    logic [4:0]         sum_raw [NDIG];

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        localparam bcd_digit_t A_DIG = dec_digit(RATE_A, g);
        localparam bcd_digit_t B_DIG = dec_digit(RATE_B, g);
        localparam bcd_digit_t S_DIG = dec_digit(START_FEE, g);

        assign addend[g]  = add_a ? A_DIG : (add_b ? B_DIG : 4'd0);
        assign sum_raw[g] = {1'b0, st_q.fare[4*g +: 4]} + {1'b0, addend[g]} + {4'b0, carry[g]};
        assign carry[g+1] = (sum_raw[g] > 5'd9);
        assign sum_vec[4*g +: 4]   = carry[g+1] ? 4'(sum_raw[g] - 5'd10) : sum_raw[g][3:0];
        assign start_vec[4*g +: 4] = S_DIG;
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.fare = start_vec;
        end else if (add_a || add_b) begin
            st_d.fare = carry[NDIG] ? {NDIG{4'd9}} : sum_vec;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fare = st_q.fare;

    AST_FARE_MONOTONIC: assert property (@(posedge clk) disable iff (clr)
        !clr |=> (st_q.fare >= $past(st_q.fare))) else $error("fare decreased"); // R4

    AST_FARE_IDLE_STEADY: assert property (@(posedge clk) disable iff (clr)
        (!add_a && !add_b) |=> $stable(st_q.fare)) else $error("fare moved without charge"); // R8

    AST_FARE_SATURATED_HOLDS: assert property (@(posedge clk) disable iff (clr)
        (st_q.fare == {NDIG{4'd9}}) |=> (st_q.fare == {NDIG{4'd9}})) else $error("saturated fare left limit"); // R10

endmodule

// File: rtl/taxi_meter.sv
module taxi_meter
    import taxi_meter_pkg::*;
#(
    parameter int FARE_DIGITS   = 4,
    parameter int COUNT_DIGITS  = 2,
    parameter int PULSES_PER_KM = 10,
    parameter int START_FEE     = 50,
    parameter int KM_RATE       = 14,
    parameter int MIN_RATE      = 13,
    parameter int FREE_KM       = 2,
    parameter int FREE_MIN      = 2
) (
    input  logic                       clk,
    input  logic                       start,
    input  logic                       stop,
    input  logic                       wheel_pulse,
    input  logic                       minute_tick,
    output logic [4*FARE_DIGITS-1:0]   fare_bcd,
    output logic [4*COUNT_DIGITS-1:0]  km_bcd,
    output logic [4*COUNT_DIGITS-1:0]  min_bcd,
    output logic                       en_dist,
    output logic                       en_wait
);

    logic clr;
    logic drive_pulse;
    logic wait_tick;
    logic km_step;
    logic add_dist;
    logic add_wait;

    assign clr         = !start;
    assign drive_pulse = start && !stop && wheel_pulse;
    assign wait_tick   = start && stop && minute_tick;

    taxi_wheel_divider #(
        .PULSES_PER_KM (PULSES_PER_KM)
    ) i_divider (
        .clk      (clk),
        .clr      (clr),
        .pulse_en (drive_pulse),
        .km_step  (km_step)
    );

    taxi_bcd_counter #(
        .NDIG (COUNT_DIGITS)
    ) i_km_count (
        .clk   (clk),
        .clr   (clr),
        .inc   (km_step),
        .value (km_bcd)
    );

    taxi_bcd_counter #(
        .NDIG (COUNT_DIGITS)
    ) i_min_count (
        .clk   (clk),
        .clr   (clr),
        .inc   (wait_tick),
        .value (min_bcd)
    );

    taxi_rate_select #(
        .NDIG     (COUNT_DIGITS),
        .FREE_KM  (FREE_KM),
        .FREE_MIN (FREE_MIN)
    ) i_rate_sel (
        .run       (start),
        .stop      (stop),
        .km_value  (km_bcd),
        .min_value (min_bcd),
        .km_step   (km_step),
        .min_step  (wait_tick),
        .en_dist   (en_dist),
        .en_wait   (en_wait),
        .add_dist  (add_dist),
        .add_wait  (add_wait)
    );

    taxi_fare_accum #(
        .NDIG      (FARE_DIGITS),
        .START_FEE (START_FEE),
        .RATE_A    (KM_RATE),
        .RATE_B    (MIN_RATE)
    ) i_fare (
        .clk   (clk),
        .clr   (clr),
        .add_a (add_dist),
        .add_b (add_wait),
        .fare  (fare_bcd)
    );

    AST_SINGLE_RATE_SOURCE: assert property (@(posedge clk) disable iff (!start)
        !(en_dist && en_wait)) else $error("both tariffs armed"); // R11

    AST_KM_HELD_WHILE_WAITING: assert property (@(posedge clk) disable iff (!start)
        stop |=> $stable(km_bcd)) else $error("distance moved while waiting"); // R5

    AST_MINUTE_ADVANCES: assert property (@(posedge clk) disable iff (!start)
        (stop && minute_tick) |=> !$stable(min_bcd)) else $error("minute tick lost"); // R5

    AST_NO_WAIT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!start)
        !stop |=> $stable(min_bcd)) else $error("waiting time moved while driving"); // R5

endmodule

// File: tb/test_taxi_meter.sv
`timescale 1ns/1ps
module test_taxi_meter;

    logic        clk = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        wheel_pulse = 1'b0;
    logic        minute_tick = 1'b0;
    logic [15:0] fare_bcd;
    logic [7:0]  km_bcd;
    logic [7:0]  min_bcd;
    logic        en_dist;
    logic        en_wait;

    int n_checks = 0;
    int n_fails  = 0;

    // decimal model state
    int m_km = 0, m_min = 0, m_sub = 0, m_fare = 50;

    always #2 clk = ~clk;

    taxi_meter i_taxi_meter (
        .clk         (clk),
        .start       (start),
        .stop        (stop),
        .wheel_pulse (wheel_pulse),
        .minute_tick (minute_tick),
        .fare_bcd    (fare_bcd),
        .km_bcd      (km_bcd),
        .min_bcd     (min_bcd),
        .en_dist     (en_dist),
        .en_wait     (en_wait)
    );

    function automatic int dec_of(input logic [15:0] v, input int nd);
        int acc = 0;
        for (int k = nd - 1; k >= 0; k--) begin
            if (v[4*k +: 4] > 4'd9) return -1;
            acc = acc * 10 + int'(v[4*k +: 4]);
        end
        return acc;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic add_fare(input int amt);
        m_fare = (m_fare + amt > 9999) ? 9999 : m_fare + amt;
    endtask

    task automatic cycle(input logic s, input logic st, input logic p, input logic t);
        start = s; stop = st; wheel_pulse = p; minute_tick = t;
        @(posedge clk);
        #1;
        if (!s) begin
            m_km = 0; m_min = 0; m_sub = 0; m_fare = 50;
        end else if (st) begin
            if (t) begin
                if (m_min > 2) add_fare(13);
                m_min = (m_min + 1) % 100;
            end
        end else if (p) begin
            if (m_sub == 9) begin
                m_sub = 0;
                if (m_km > 2) add_fare(14);
                m_km = (m_km + 1) % 100;
            end else begin
                m_sub++;
            end
        end
        check("R2 R9 km", dec_of({8'h00, km_bcd}, 2), m_km);
        check("R5 R9 minutes", dec_of({8'h00, min_bcd}, 2), m_min);
        check("R4 R7 R8 R10 fare", dec_of(fare_bcd, 4), m_fare);
        check("R3 en_dist", int'(en_dist), int'(s && !st && m_km > 2));
        check("R6 en_wait", int'(en_wait), int'(s && st && m_min > 2));
        check("R11 one tariff", int'(en_dist && en_wait), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic        run_stop;
        lfsr     = 16'hACE1;
        run_stop = 1'b0;

        // R1: reset state
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0);
        check("R1 fare", int'(fare_bcd), 32'h0050);
        check("R1 km", int'(km_bcd), 0);
        check("R1 minutes", int'(min_bcd), 0);
        check("R1 flags", int'({en_dist, en_wait}), 0);

        // R8: within free distance and free waiting
        for (int i = 0; i < 29; i++) cycle(1, 0, 1, 0);
        for (int i = 0; i < 2; i++) cycle(1, 1, 0, 1);
        check("R8 fee held", int'(fare_bcd), 32'h0050);
        check("R3 not armed at 2 km", int'(en_dist), 0);
        cycle(1, 0, 1, 0);
        check("R2 third km", int'(km_bcd), 32'h03);
        check("R3 armed above 2 km", int'(en_dist), 1);
        check("R8 third km free", int'(fare_bcd), 32'h0050);

        // pseudo-random sweep over all modes
        for (int i = 0; i < 30000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:11] == 5'd0) run_stop = !run_stop;
            cycle(lfsr[10:2] != 9'd0, run_stop, lfsr[0], lfsr[3] & lfsr[5]);
        end

        // R1: clear mid-run
        cycle(0, 0, 1, 1);
        check("R1 clear fare", int'(fare_bcd), 32'h0050);
        check("R1 clear km", int'(km_bcd), 0);

        // R9 / R4: 100 km wraps the distance
        for (int i = 0; i < 1000; i++) cycle(1, 0, 1, 0);
        check("R9 km wrap", int'(km_bcd), 0);
        check("R4 fare after 100 km", dec_of(fare_bcd, 4), 50 + 97 * 14);

        // R9 / R7: 100 minutes wraps waiting time
        for (int i = 0; i < 100; i++) cycle(1, 1, 0, 1);
        check("R9 minute wrap", int'(min_bcd), 0);
        check("R7 fare after 100 min", dec_of(fare_bcd, 4), 50 + 97 * 14 + 97 * 13);

        // R5: wheel pulses ignored while waiting
        for (int i = 0; i < 25; i++) cycle(1, 1, 1, 0);
        check("R5 km unchanged", int'(km_bcd), 0);
        check("R5 en_dist low", int'(en_dist), 0);
        for (int i = 0; i < 10; i++) cycle(1, 0, 1, 0);
        check("R5 no partial slices kept", int'(km_bcd), 32'h01);

        // R10: saturation
        for (int i = 0; i < 10000; i++) cycle(1, 0, 1, 0);
        check("R10 saturated", int'(fare_bcd), 32'h9999);
        for (int i = 0; i < 40; i++) cycle(1, 1, 0, 1);
        check("R10 held at limit", int'(fare_bcd), 32'h9999);
        cycle(0, 0, 0, 0);
        check("R1 clear after limit", int'(fare_bcd), 32'h0050);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule